// File: doc/BRIEF.md
# Router Lifetime Budget Accumulator

This block tracks how much wear-out headroom one network router has left. It works over fixed monitoring intervals of `INTERVAL_CYCLES` clock cycles. During an interval it counts the flits that arrive at the router. It does not care which input port a flit came through: every cycle with the arrival strobe high adds one to the count. In the last cycle of an interval it reads a wear factor from a table indexed by the quantized temperature code. It multiplies that factor by the flit count to get the failure rate for the interval. It then adds the programmed nominal consumption rate to a signed budget register and subtracts the failure rate.

The exponential temperature dependence of wear is never computed in hardware. It is folded ahead of time into the factor table, which is supplied as a parameter. The budget reads zero from reset, which is interval zero. A positive value means the router is wearing more slowly than its lifetime target allows. A negative value means it is wearing faster. A routing stage can read the budget and steer traffic towards routers that have more headroom. The register saturates at its signed limits instead of wrapping, so a router under long stress never appears to have a large surplus.

Top module: `lifetime_budget_acc`

## Requirements
- R1: While `rst` is high, and from its release until the first update, `budget` reads 0 and `budget_upd` reads 0.
- R2: `budget` changes only at the end of each interval of `INTERVAL_CYCLES` cycles. Counting the first cycle after reset release as cycle 0, the first new value is visible in cycle `INTERVAL_CYCLES`, and each later update follows exactly `INTERVAL_CYCLES` cycles after the previous one.
- R3: Each update sets budget = previous budget + `nominal_rate` − factor × flit count, where `nominal_rate` is unsigned and the result is taken as a signed value.
- R4: Every cycle of the interval in which `flit_arrive` is high counts as one flit, the interval's first and last cycles included. The count starts again from zero in each interval.
- R5: The flit count of an interval saturates at 2^`CNT_W` − 1 and does not wrap.
- R6: `temp_code` and `nominal_rate` are used only in the last cycle of an interval. Their values in every other cycle have no effect on the budget.
- R7: The factor for temperature code i is the unsigned field `FACTOR_TABLE[i*FACTOR_W +: FACTOR_W]`.
- R8: `budget` is two's complement and `BUDGET_W` bits wide. A result above 2^(`BUDGET_W`−1) − 1 holds at that maximum, and a result below −2^(`BUDGET_W`−1) holds at that minimum.
- R9: `budget_upd` is high for exactly one cycle: the cycle in which the newly written budget first appears on `budget`. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flit_arrive | input | 1 | One flit entered the router in this cycle |
| temp_code | input | TEMP_W | Quantized temperature code, indexes the factor table |
| nominal_rate | input | RATE_W | Unsigned nominal consumption rate added each interval |
| budget | output | BUDGET_W | Signed lifetime budget |
| budget_upd | output | 1 | One-cycle pulse marking a fresh budget value |

## Verification
The bench builds the block with a 20-cycle interval, a 4-bit flit counter, an 8-entry table of 6-bit factors (entry i = 3i + 1) and a 12-bit budget. These parameters do not change the block's function. The 20-cycle interval lets about seventy intervals run in a short run. With at most 20 arrivals per interval, the 4-bit counter saturates whenever the traffic is dense. The 12-bit budget can be driven to both signed limits within about a dozen intervals of full nominal rate, or of full traffic at the hottest code. The bench also fills the non-final cycles of some intervals with random temperature codes and nominal rates, so that a design sampling either input at the wrong time shows a mismatch.

// File: rtl/lb_pkg.sv
package lb_pkg;

   // Two ways to build the interval timer.
   typedef enum logic [0:0] {
      TMR_POW2    = 1'b0,   // free-running counter wraps on its own
      TMR_COMPARE = 1'b1    // counter compared against the last index
   } lb_timer_kind_e;

   function automatic lb_timer_kind_e lb_pick_timer(input int unsigned cycles);
      if ((cycles & (cycles - 1)) == 0)
         return TMR_POW2;
      return TMR_COMPARE;
   endfunction

   // Bits needed to hold the value v.
   function automatic int unsigned lb_bits(input longint unsigned v);
      int unsigned n;
      n = 1;
      while ((v >> n) != 0)
         n++;
      return n;
   endfunction

endpackage

// File: rtl/lb_interval_timer.sv
module lb_interval_timer
   import lb_pkg::*;
#(
   parameter int unsigned INTERVAL_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   localparam int unsigned TW   = $clog2(INTERVAL_CYCLES);
   localparam lb_timer_kind_e KIND = lb_pick_timer(INTERVAL_CYCLES);
   localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYCLES - 1);

   logic [TW-1:0] phase;

   generate
      if (KIND == TMR_POW2) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst) phase <= '0;
            else     phase <= phase + 1'b1;
         end
         assign tick = &phase;
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst)               phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                   phase <= phase + 1'b1;
         end
         assign tick = (phase == LAST);
      end
   endgenerate

endmodule

// File: rtl/lb_flit_counter.sv
module lb_flit_counter #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flit_arrive,
   input  logic             tick,
   output logic [CNT_W-1:0] sample
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] count;

   // Count including this cycle's arrival, held at the top value.
   always_comb begin
      if (flit_arrive && (count != CNT_MAX)) sample = count + 1'b1;
      else                                   sample = count;
   end

   always_ff @(posedge clk) begin
      if (rst)       count <= '0;
      else if (tick) count <= '0;
      else           count <= sample;
   end

endmodule

// File: rtl/lb_wear_rate.sv
module lb_wear_rate #(
   parameter int unsigned TEMP_W   = 3,
   parameter int unsigned FACTOR_W = 8,
   parameter int unsigned CNT_W    = 13,
   parameter logic [(2**TEMP_W)*FACTOR_W-1:0] FACTOR_TABLE = '0
) (
   input  logic [TEMP_W-1:0]         temp_code,
   input  logic [CNT_W-1:0]          flits,
   output logic [FACTOR_W+CNT_W-1:0] rate
);

   localparam int unsigned DEPTH  = 2**TEMP_W;
   localparam int unsigned PROD_W = FACTOR_W + CNT_W;

   logic [FACTOR_W-1:0] factor_arr [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         assign factor_arr[g] = FACTOR_TABLE[g*FACTOR_W +: FACTOR_W];
      end
   endgenerate

   assign rate = PROD_W'(factor_arr[temp_code]) * PROD_W'(flits);

endmodule

// File: rtl/lb_budget_reg.sv
module lb_budget_reg #(
   parameter int unsigned RATE_W   = 16,
   parameter int unsigned PROD_W   = 21,
   parameter int unsigned BUDGET_W = 40
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       tick,
   input  logic [RATE_W-1:0]          nominal_rate,
   input  logic [PROD_W-1:0]          rate,
   output logic signed [BUDGET_W-1:0] budget,
   output logic                       budget_upd
);

   localparam int unsigned SUM_W = BUDGET_W + 2;
   localparam logic signed [SUM_W-1:0] SAT_HI =
      {2'b00, 1'b0, {(BUDGET_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] SAT_LO =
      {2'b11, 1'b1, {(BUDGET_W-1){1'b0}}};

   logic signed [SUM_W-1:0]    cur_x, nom_x, rate_x, sum;
   logic signed [BUDGET_W-1:0] next_budget;

   always_comb begin
      cur_x  = {{2{budget[BUDGET_W-1]}}, budget};
      nom_x  = {{(SUM_W-RATE_W){1'b0}}, nominal_rate};
      rate_x = {{(SUM_W-PROD_W){1'b0}}, rate};
      sum    = cur_x + nom_x - rate_x;
      if (sum > SAT_HI)      next_budget = SAT_HI[BUDGET_W-1:0];
      else if (sum < SAT_LO) next_budget = SAT_LO[BUDGET_W-1:0];
      else                   next_budget = sum[BUDGET_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         budget     <= '0;
         budget_upd <= 1'b0;
      end else begin
         budget_upd <= tick;
         if (tick) budget <= next_budget;
      end
   end

endmodule

// File: rtl/lifetime_budget_acc.sv
module lifetime_budget_acc
   import lb_pkg::*;
#(
   parameter int unsigned INTERVAL_CYCLES = 5000,
   parameter int unsigned CNT_W           = 13,
   parameter int unsigned TEMP_W          = 3,
   parameter int unsigned FACTOR_W        = 8,
   parameter int unsigned RATE_W          = 16,
   parameter int unsigned BUDGET_W        = 40,
   parameter logic [(2**TEMP_W)*FACTOR_W-1:0] FACTOR_TABLE =
      64'h40_2C_1E_14_0D_08_05_03
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       flit_arrive,
   input  logic [TEMP_W-1:0]          temp_code,
   input  logic [RATE_W-1:0]          nominal_rate,
   output logic signed [BUDGET_W-1:0] budget,
   output logic                       budget_upd
);

   localparam int unsigned PROD_W = FACTOR_W + CNT_W;

   // Elaboration-time parameter checks.
   generate
      if (INTERVAL_CYCLES < 2) begin : g_bad_interval
         $error("INTERVAL_CYCLES must be at least 2");
      end
      if (CNT_W < 1 || TEMP_W < 1 || FACTOR_W < 1 || RATE_W < 1) begin : g_bad_width
         $error("all widths must be at least 1");
      end
      if (BUDGET_W <= RATE_W || BUDGET_W <= PROD_W) begin : g_bad_budget
         $error("BUDGET_W must exceed RATE_W and FACTOR_W+CNT_W");
      end
      if (lb_bits(longint'(INTERVAL_CYCLES)) > 32) begin : g_bad_span
         $error("INTERVAL_CYCLES too large");
      end
   endgenerate

   logic             tick;
   logic [CNT_W-1:0] flits;
   logic [PROD_W-1:0] rate;

   lb_interval_timer #(
      .INTERVAL_CYCLES(INTERVAL_CYCLES)
   ) u_timer (
      .clk (clk),
      .rst (rst),
      .tick(tick)
   );

   lb_flit_counter #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk        (clk),
      .rst        (rst),
      .flit_arrive(flit_arrive),
      .tick       (tick),
      .sample     (flits)
   );

   lb_wear_rate #(
      .TEMP_W      (TEMP_W),
      .FACTOR_W    (FACTOR_W),
      .CNT_W       (CNT_W),
      .FACTOR_TABLE(FACTOR_TABLE)
   ) u_rate (
      .temp_code(temp_code),
      .flits    (flits),
      .rate     (rate)
   );

   lb_budget_reg #(
      .RATE_W  (RATE_W),
      .PROD_W  (PROD_W),
      .BUDGET_W(BUDGET_W)
   ) u_budget (
      .clk         (clk),
      .rst         (rst),
      .tick        (tick),
      .nominal_rate(nominal_rate),
      .rate        (rate),
      .budget      (budget),
      .budget_upd  (budget_upd)
   );

endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
   parameter int unsigned INTERVAL_CYCLES = 5000,
   parameter int unsigned BUDGET_W        = 40
) (
   input logic                       clk,
   input logic                       rst,
   input logic signed [BUDGET_W-1:0] budget,
   input logic                       budget_upd
);

   localparam int unsigned GW = $clog2(INTERVAL_CYCLES + 2) + 1;
   localparam logic [GW-1:0] GAP_TOP = '1;

   logic          rst_q;
   logic [GW-1:0] gap;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)             gap <= '0;
      else if (budget_upd) gap <= GW'(1);
      else if (gap != GAP_TOP) gap <= gap + 1'b1;
   end

   // R1: cleared state seen in the first cycle after reset release
   always @(posedge clk) begin
      if (rst_q === 1'b1 && rst === 1'b0)
         a_r1_reset_clear: assert (budget == '0 && budget_upd == 1'b0);
   end

   // R2: budget moves only in the cycle flagged as an update
   a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
      (budget != $past(budget)) |-> budget_upd);

   // R2: updates are spaced by exactly one interval
   a_r2_interval_spacing: assert property (@(posedge clk) disable iff (rst)
      budget_upd |-> (gap == GW'(INTERVAL_CYCLES)));

   // R9: the update flag lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
      budget_upd |=> !budget_upd);

endmodule

bind lifetime_budget_acc lb_checker #(
   .INTERVAL_CYCLES(INTERVAL_CYCLES),
   .BUDGET_W       (BUDGET_W)
) u_lb_checker (
   .clk       (clk),
   .rst       (rst),
   .budget    (budget),
   .budget_upd(budget_upd)
);

// File: tb/lifetime_budget_acc_test.sv
`timescale 1ns/1ps
module lifetime_budget_acc_test;

   localparam int N     = 20;
   localparam int CW    = 4;
   localparam int TW    = 3;
   localparam int FW    = 6;
   localparam int RW    = 8;
   localparam int BW    = 12;
   localparam int DEPTH = 8;
   localparam int CMAX  = (1 << CW) - 1;

   function automatic logic [DEPTH*FW-1:0] mk_tbl();
      logic [DEPTH*FW-1:0] r;
      r = '0;
      for (int i = 0; i < DEPTH; i++) r[i*FW +: FW] = FW'(3*i + 1);
      return r;
   endfunction

   localparam logic [DEPTH*FW-1:0] TBL = mk_tbl();

   // R7: independent model of the table, entry i = 3i+1
   function automatic longint fac(input int t);
      return longint'(3*t + 1);
   endfunction

   // R8: clamp to the signed range of the budget
   function automatic longint clampb(input longint v);
      longint hi, lo;
      hi = (longint'(1) <<< (BW-1)) - 1;
      lo = -(longint'(1) <<< (BW-1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 flit_arrive = 1'b0;
   logic [TW-1:0]        temp_code = '0;
   logic [RW-1:0]        nominal_rate = '0;
   logic signed [BW-1:0] budget;
   logic                 budget_upd;

   int     checks = 0;
   int     fails  = 0;
   bit     done   = 0;
   bit     have_prev = 0;
   longint model = 0;

   always #10 clk = ~clk;

   lifetime_budget_acc #(
      .INTERVAL_CYCLES(N),
      .CNT_W          (CW),
      .TEMP_W         (TW),
      .FACTOR_W       (FW),
      .RATE_W         (RW),
      .BUDGET_W       (BW),
      .FACTOR_TABLE   (TBL)
   ) uut (
      .clk         (clk),
      .rst         (rst),
      .flit_arrive (flit_arrive),
      .temp_code   (temp_code),
      .nominal_rate(nominal_rate),
      .budget      (budget),
      .budget_upd  (budget_upd)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // mode: 0 none, 1 every cycle, 2 random, 3 one flit, 4 first and last cycle
   task automatic run_interval(input int mode, input int nom, input int tcode,
                               input bit noisy, input string tag);
      int cnt;
      bit fl;
      cnt = 0;
      for (int k = 0; k < N; k++) begin
         if (k == 0) begin
            if (have_prev) begin
               chk(budget_upd === 1'b1, "R9", longint'(budget_upd), 1);
               chk(longint'(budget) == model, tag, longint'(budget), model);
            end else begin
               chk(budget_upd === 1'b0, "R2", longint'(budget_upd), 0);
               chk(longint'(budget) == 0, "R1", longint'(budget), 0);
            end
         end else if (k == N-1) begin
            // R2: no early update in the last cycle of the interval
            chk(budget_upd === 1'b0, "R9", longint'(budget_upd), 0);
            chk(longint'(budget) == model, "R2", longint'(budget), model);
         end
         case (mode)
            0:       fl = 1'b0;
            1:       fl = 1'b1;
            2:       fl = 1'($urandom_range(0, 1));
            3:       fl = (k == 3);
            default: fl = (k == 0) || (k == N-1);
         endcase
         flit_arrive = fl;
         if (fl) cnt++;
         if (k == N-1 || !noisy) begin
            temp_code    = TW'(tcode);
            nominal_rate = RW'(nom);
         end else begin
            temp_code    = TW'($urandom_range(0, DEPTH-1));
            nominal_rate = RW'($urandom_range(0, 255));
         end
         @(negedge clk);
      end
      model = clampb(model + longint'(nom) - fac(tcode) * longint'((cnt > CMAX) ? CMAX : cnt));
      have_prev = 1;
   endtask

   initial begin
      void'($urandom(32'd7341));
      repeat (4) @(negedge clk);
      chk(budget == '0, "R1", longint'(budget), 0);
      chk(budget_upd === 1'b0, "R1", longint'(budget_upd), 0);
      rst = 1'b0;

      run_interval(0, 100, 2, 1'b0, "R3");  // idle interval: +100
      run_interval(1, 0, 7, 1'b0, "R3");    // full traffic at hottest code
      run_interval(1, 0, 7, 1'b0, "R5");    // 20 arrivals clipped to 15
      run_interval(4, 50, 3, 1'b0, "R3");
      run_interval(0, 0, 0, 1'b0, "R4");    // edge-cycle flits counted
      for (int t = 0; t < DEPTH; t++)
         run_interval(3, 0, t, 1'b0, "R7");
      run_interval(2, 90, 5, 1'b1, "R7");
      for (int i = 0; i < 4; i++)
         run_interval(3, 40, 6, 1'b1, "R6");
      for (int i = 0; i < 14; i++)
         run_interval(0, 255, 0, 1'b0, "R8");
      run_interval(0, 255, 0, 1'b1, "R8");
      for (int i = 0; i < 16; i++)
         run_interval(1, 0, 7, 1'b0, "R8");
      run_interval(1, 0, 7, 1'b1, "R8");
      for (int i = 0; i < 24; i++)
         run_interval(2, $urandom_range(0, 255), $urandom_range(0, DEPTH-1),
                      1'($urandom_range(0, 1)), "R3");

      chk(budget_upd === 1'b1, "R9", longint'(budget_upd), 1);
      chk(longint'(budget) == model, "R3", longint'(budget), model);
      @(negedge clk);
      chk(budget_upd === 1'b0, "R9", longint'(budget_upd), 0);
      chk(longint'(budget) == model, "R2", longint'(budget), model);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule